// File: doc/BRIEF.md
# Three-Phase Bridge Shoot-Through Guard

This block sits between a PWM generator and the gate drivers of a three-phase half-bridge inverter with a dynamic-brake switch. Each phase has an upper and a lower command input. Both are active-low: a low level asks for the switch to conduct. The block passes each command to an active-high gate output.

If a phase sees both of its commands low at once, the block blocks that phase. Both of its gates are forced off and a shared fault flag is pulled low. The block holds this state until the command stream shows that a real new single command has begun.

Each of the six inverter switches also has two comparator inputs, one for short circuit and one for current limit. A short circuit cuts only the gate of the switch that sensed it, and it pulls the shared fault flag low. A current-limit event pulls a separate warning flag low and leaves the gates alone. Both conditions are held until that switch starts its next command pulse, so protection runs pulse by pulse.

All inputs are brought into the clock domain through a two-stage synchronizer, and edges are detected after it. The brake gate follows its own command only.

Top module: `bridge_guard`

## Requirements
- R1: While reset is low, all gate outputs are 0 and both `flt_n` and `cl_n` are 1, whatever the inputs are.
- R2: A command level of 0 sampled on one clock edge appears as gate 1 (and a level of 1 as gate 0) after the second following rising edge, for every upper, lower and brake switch.
- R3: When the upper and lower commands of a phase are both 0, both gates of that phase are 0 and `flt_n` is 0, with the R2 latency. The other phases are not affected, and no phase ever has both gates at 1.
- R4: Once a phase has tripped, both of its gates stay at 0 and `flt_n` stays 0 even when only one command of that phase is 0 or both are 1, until the release of R5.
- R5: A tripped phase releases only after both of its commands have been seen at 1. The first 1-to-0 transition of one command while the other is at 1 then releases it. In that same cycle the commanded gate goes to 1 and `flt_n` returns to 1 (if nothing else holds it low).
- R6: A short-circuit input at 1 for a switch whose command is 0 forces that switch's gate to 0 and `flt_n` to 0, with the R2 latency. The other gates are not affected.
- R7: The short-circuit cut-off persists after the sense input returns to 0, and through the following off time. It clears on the switch's next 1-to-0 command transition, and in that cycle the gate turns on again.
- R8: A current-limit input at 1 for a switch whose command is 0 drives `cl_n` to 0 with the R2 latency and leaves the gates unchanged. `cl_n` stays 0 until that switch's next 1-to-0 command transition.
- R9: The brake gate follows only the brake command. Phase interlock and short-circuit events do not affect it.
- R10: Short-circuit and current-limit inputs at 1 while the switch's command is 1 are ignored. They cause no flag and no cut-off of the switch's following pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_hi_n | input | PHASES | Upper-switch commands, 0 = on |
| cmd_lo_n | input | PHASES | Lower-switch commands, 0 = on |
| brk_cmd_n | input | 1 | Brake-switch command, 0 = on |
| sc_hi | input | PHASES | Upper-switch short-circuit comparators, 1 = event |
| sc_lo | input | PHASES | Lower-switch short-circuit comparators, 1 = event |
| oc_hi | input | PHASES | Upper-switch current-limit comparators, 1 = event |
| oc_lo | input | PHASES | Lower-switch current-limit comparators, 1 = event |
| gate_hi | output | PHASES | Upper gate enables, 1 = conduct |
| gate_lo | output | PHASES | Lower gate enables, 1 = conduct |
| brk_gate | output | 1 | Brake gate enable, 1 = conduct |
| flt_n | output | 1 | Shared interlock/short-circuit fault, 0 = fault |
| cl_n | output | 1 | Current-limit warning, 0 = warning |

## Verification
Every result, whether a gate change, a fault or warning onset, a latched state or a release, is due after the second rising edge that follows the input change, because of the two synchronizer flops. The release of a latch takes effect in that same cycle, not one later. The bench drives inputs on the falling edge. It then waits exactly two rising edges and samples 1 ns later. For the latency requirement it also samples after the first edge and expects the old value there. Latched conditions are checked again after further input steps with the same two-edge wait, so each hold and each release is seen at its due cycle.

// File: rtl/bg_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bridge guard.
// Assumes nothing beyond a single clock domain after synchronization.
package bg_pkg;
    parameter int unsigned BG_SYNC_STAGES = 2;

    // Per-switch status produced by each switch guard.
    typedef struct packed {
        logic gate;   // gate enable, 1 = conduct
        logic fall;   // command 1->0 transition this cycle (new pulse)
        logic sc;     // short-circuit cut-off active
        logic warn;   // current-limit warning active
    } sw_stat_t;
endpackage

// File: rtl/bg_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a bus of independent level signals.
// Assumes each bit is a slow level; no bus coherency is implied.
module bg_sync #(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] sr [STAGES];

    // Shift the raw bus through the flop chain, loading the idle value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) sr[i] <= RST_VAL;
        end else begin
            sr[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) sr[i] <= sr[i-1];
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/bg_switch_guard.sv
`timescale 1ns/1ps
// Per-switch guard: detects new command pulses, holds short-circuit
// cut-off and current-limit warning until the next pulse, and forms the gate.
// Assumes synchronized inputs; ilk comes from the phase interlock.
module bg_switch_guard
    import bg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_n,
    input  logic     sc,
    input  logic     oc,
    input  logic     ilk,
    output sw_stat_t stat
);
    logic prev_n;
    logic hold_q, warn_q;
    logic on, fall, hold, warn;

    // Remember the previous command level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= 1'b1;
        else        prev_n <= cmd_n;
    end

    // Compute the live cut-off and warning; a new pulse releases the held state.
    always_comb begin
        on   = ~cmd_n;
        fall = prev_n & ~cmd_n;
        hold = (sc & on) | (hold_q & ~fall);
        warn = (oc & on) | (warn_q & ~fall);
    end

    // Carry the cut-off and warning across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            warn_q <= 1'b0;
        end else begin
            hold_q <= hold;
            warn_q <= warn;
        end
    end

    assign stat.gate = on & ~hold & ~ilk;
    assign stat.fall = fall;
    assign stat.sc   = hold;
    assign stat.warn = warn;
endmodule

// File: rtl/bg_phase_lock.sv
`timescale 1ns/1ps
// Shoot-through interlock for one phase. Trips when both commands are on,
// latches, and releases on a new single command after both were released.
// Assumes synchronized active-low commands and falls from the switch guards.
module bg_phase_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_n,
    input  logic lo_n,
    input  logic fall_hi,
    input  logic fall_lo,
    output logic ilk
);
    logic trip_q, seen_hi_q, seen_lo_q;
    logic both, release_now;

    // Detect overlap now and a qualified release edge.
    always_comb begin
        both        = ~hi_n & ~lo_n;
        release_now = trip_q & seen_hi_q & seen_lo_q &
                      ((fall_hi & lo_n) | (fall_lo & hi_n));
        ilk         = both | (trip_q & ~release_now);
    end

    // Latch the trip and track which commands have been released since.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_q    <= 1'b0;
            seen_hi_q <= 1'b0;
            seen_lo_q <= 1'b0;
        end else begin
            trip_q <= ilk;
            if (both) begin
                seen_hi_q <= 1'b0;
                seen_lo_q <= 1'b0;
            end else if (trip_q) begin
                seen_hi_q <= seen_hi_q | hi_n;
                seen_lo_q <= seen_lo_q | lo_n;
            end
        end
    end
endmodule

// File: rtl/bridge_guard.sv
`timescale 1ns/1ps
// Bridge guard top: synchronizes all commands and comparator inputs,
// applies per-phase interlock and per-switch pulse-by-pulse protection,
// and drives gate enables plus the open-drain-style fault and warning flags.
// Assumes one clock; the brake path has no interlock and no cut-off.
module bridge_guard #(
    parameter int unsigned PHASES      = 3,
    parameter int unsigned SYNC_STAGES = bg_pkg::BG_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] cmd_hi_n,
    input  logic [PHASES-1:0] cmd_lo_n,
    input  logic              brk_cmd_n,
    input  logic [PHASES-1:0] sc_hi,
    input  logic [PHASES-1:0] sc_lo,
    input  logic [PHASES-1:0] oc_hi,
    input  logic [PHASES-1:0] oc_lo,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo,
    output logic              brk_gate,
    output logic              flt_n,
    output logic              cl_n
);
    import bg_pkg::*;

    localparam int unsigned SW = 2 * PHASES;
    localparam int unsigned W  = 3 * SW + 1;
    localparam logic [W-1:0] IDLE = {{(2*SW){1'b0}}, {(SW+1){1'b1}}};

    logic [W-1:0]    raw, syn;
    logic [SW-1:0]   s_cmd, s_sc, s_oc;
    logic            s_brk;
    logic [PHASES-1:0] ilk;
    sw_stat_t        stat [SW];
    logic [SW-1:0]   gate_v, sc_v, warn_v;

    assign raw = {oc_lo, oc_hi, sc_lo, sc_hi, brk_cmd_n, cmd_lo_n, cmd_hi_n};

    bg_sync #(.WIDTH(W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign s_cmd = syn[SW-1:0];
    assign s_brk = syn[SW];
    assign s_sc  = syn[2*SW:SW+1];
    assign s_oc  = syn[3*SW:2*SW+1];

    // Index k < PHASES is the upper switch of phase k, else the lower one.
    for (genvar p = 0; p < int'(PHASES); p++) begin : g_phase
        bg_phase_lock u_lock (
            .clk(clk), .rst_n(rst_n),
            .hi_n(s_cmd[p]), .lo_n(s_cmd[p+PHASES]),
            .fall_hi(stat[p].fall), .fall_lo(stat[p+PHASES].fall),
            .ilk(ilk[p])
        );
    end

    for (genvar k = 0; k < int'(SW); k++) begin : g_sw
        localparam int PH = k % PHASES;
        bg_switch_guard u_guard (
            .clk(clk), .rst_n(rst_n),
            .cmd_n(s_cmd[k]), .sc(s_sc[k]), .oc(s_oc[k]),
            .ilk(ilk[PH]), .stat(stat[k])
        );
        assign gate_v[k] = stat[k].gate;
        assign sc_v[k]   = stat[k].sc;
        assign warn_v[k] = stat[k].warn;
    end

    assign gate_hi  = gate_v[PHASES-1:0];
    assign gate_lo  = gate_v[SW-1:PHASES];
    assign brk_gate = ~s_brk;
    assign flt_n    = ~((|ilk) | (|sc_v));
    assign cl_n     = ~(|warn_v);
endmodule

// File: rtl/bridge_guard_chk.sv
`timescale 1ns/1ps
// Property checker for bridge_guard, observing its ports only.
// Assumes the two-stage synchronizer latency of the default build.
module bridge_guard_chk #(
    parameter int unsigned PHASES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PHASES-1:0] cmd_hi_n,
    input logic [PHASES-1:0] cmd_lo_n,
    input logic              brk_cmd_n,
    input logic [PHASES-1:0] sc_hi,
    input logic [PHASES-1:0] sc_lo,
    input logic [PHASES-1:0] oc_hi,
    input logic [PHASES-1:0] oc_lo,
    input logic [PHASES-1:0] gate_hi,
    input logic [PHASES-1:0] gate_lo,
    input logic              brk_gate,
    input logic              flt_n,
    input logic              cl_n
);
    for (genvar p = 0; p < int'(PHASES); p++) begin : g_p
        // R3
        arm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[p] && gate_lo[p]));
        // R2
        hi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_hi[p] |-> $past(!cmd_hi_n[p], 2));
        // R2
        lo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_lo[p] |-> $past(!cmd_lo_n[p], 2));
        // R3
        both_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 1) && $past(rst_n, 2) &&
             $past(!cmd_hi_n[p] && !cmd_lo_n[p], 2)) |-> !flt_n);
        // R6
        sc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 1) && $past(rst_n, 2) &&
             $past(sc_lo[p] && !cmd_lo_n[p], 2)) |-> (!gate_lo[p] && !flt_n));
        // R8
        warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 1) && $past(rst_n, 2) &&
             $past(oc_hi[p] && !cmd_hi_n[p], 2)) |-> !cl_n);
    end

    // R9
    brake_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (brk_gate == $past(!brk_cmd_n, 2)));
endmodule

bind bridge_guard bridge_guard_chk #(.PHASES(PHASES)) u_chk (.*);

// File: tb/bridge_guard_test.sv
`timescale 1ns/1ps
module bridge_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_hi_n = 3'b111, cmd_lo_n = 3'b111;
    logic       brk_cmd_n = 1'b1;
    logic [2:0] sc_hi = '0, sc_lo = '0, oc_hi = '0, oc_lo = '0;
    logic [2:0] gate_hi, gate_lo;
    logic       brk_gate, flt_n, cl_n;
    int         vecs = 0, errs = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    bridge_guard uut (
        .clk(clk), .rst_n(rst_n), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
        .brk_cmd_n(brk_cmd_n), .sc_hi(sc_hi), .sc_lo(sc_lo), .oc_hi(oc_hi),
        .oc_lo(oc_lo), .gate_hi(gate_hi), .gate_lo(gate_lo), .brk_gate(brk_gate),
        .flt_n(flt_n), .cl_n(cl_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_edge();
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive_edge();
        cmd_hi_n = 3'b111; cmd_lo_n = 3'b111; brk_cmd_n = 1'b1;
        sc_hi = '0; sc_lo = '0; oc_hi = '0; oc_lo = '0;
        settle();
    endtask

    // R1: outputs idle while reset is held, even with commands on.
    task automatic t_reset();
        cmd_hi_n = 3'b000; brk_cmd_n = 1'b0; oc_hi = 3'b111;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 gates", {gate_hi, gate_lo, brk_gate}, 7'b0);
        chk("R1 flags", {flt_n, cl_n}, 2'b11);
        drive_edge();
        cmd_hi_n = 3'b111; brk_cmd_n = 1'b1; oc_hi = '0;
        rst_n = 1'b1;
        settle();
        chk("R1 after release", {gate_hi, gate_lo, brk_gate, flt_n, cl_n}, 9'b000000011);
    endtask

    // R2: two-edge pass-through for each kind of switch.
    task automatic t_pass();
        drive_edge();
        cmd_hi_n = 3'b110; cmd_lo_n = 3'b101; brk_cmd_n = 1'b0;
        @(posedge clk); #1;
        chk("R2 not yet", {gate_hi, gate_lo, brk_gate}, 7'b0);
        @(posedge clk); #1;
        chk("R2 gate_hi", gate_hi, 3'b001);
        chk("R2 gate_lo", gate_lo, 3'b010);
        chk("R2 brake", brk_gate, 1'b1);
        chk("R2 no fault", {flt_n, cl_n}, 2'b11);
        idle();
        chk("R2 off again", {gate_hi, gate_lo, brk_gate}, 7'b0);
    endtask

    // R3/R4/R5/R9: overlap trip, latch, qualified release.
    task automatic t_interlock();
        drive_edge();
        cmd_hi_n = 3'b100; cmd_lo_n = 3'b101; brk_cmd_n = 1'b0;
        settle();
        chk("R3 phase1 cut, phase0 kept", {gate_hi, gate_lo}, 6'b001000);
        chk("R3 fault", flt_n, 1'b0);
        chk("R9 brake unaffected", brk_gate, 1'b1);
        drive_edge();
        cmd_hi_n = 3'b110;
        settle();
        chk("R4 lower held off", gate_lo, 3'b000);
        chk("R4 fault held", flt_n, 1'b0);
        drive_edge();
        cmd_lo_n = 3'b111;
        settle();
        chk("R4 fault held idle", flt_n, 1'b0);
        drive_edge();
        cmd_lo_n = 3'b101;
        settle();
        chk("R5 released gate", gate_lo, 3'b010);
        chk("R5 fault cleared", flt_n, 1'b1);
        chk("R5 phase0 kept", gate_hi, 3'b001);
        idle();
    endtask

    // R6/R7/R9: short-circuit cut-off held until the next pulse.
    task automatic t_short();
        drive_edge();
        cmd_lo_n = 3'b011; cmd_hi_n = 3'b110; brk_cmd_n = 1'b0;
        settle();
        chk("R6 pre", gate_lo, 3'b100);
        drive_edge();
        sc_lo = 3'b100;
        settle();
        chk("R6 cut", gate_lo, 3'b000);
        chk("R6 others", gate_hi, 3'b001);
        chk("R6 fault", flt_n, 1'b0);
        chk("R9 brake", brk_gate, 1'b1);
        drive_edge();
        sc_lo = 3'b000;
        settle();
        chk("R7 held", {gate_lo, flt_n}, 4'b0000);
        drive_edge();
        cmd_lo_n = 3'b111;
        settle();
        chk("R7 held off-time", flt_n, 1'b0);
        drive_edge();
        cmd_lo_n = 3'b011;
        settle();
        chk("R7 new pulse gate", gate_lo, 3'b100);
        chk("R7 new pulse flag", flt_n, 1'b1);
        idle();
    endtask

    // R8: current-limit warning pulse by pulse, gates untouched.
    task automatic t_warn();
        drive_edge();
        cmd_hi_n = 3'b110;
        oc_hi = 3'b001;
        settle();
        chk("R8 warn", cl_n, 1'b0);
        chk("R8 gate kept", gate_hi, 3'b001);
        chk("R8 no fault", flt_n, 1'b1);
        drive_edge();
        oc_hi = 3'b000;
        cmd_hi_n = 3'b111;
        settle();
        chk("R8 warn held", cl_n, 1'b0);
        drive_edge();
        cmd_hi_n = 3'b110;
        settle();
        chk("R8 warn cleared", cl_n, 1'b1);
        idle();
    endtask

    // R10: sense inputs while off are ignored.
    task automatic t_ignore();
        drive_edge();
        sc_hi = 3'b111; sc_lo = 3'b111; oc_lo = 3'b111;
        settle();
        chk("R10 flags", {flt_n, cl_n}, 2'b11);
        drive_edge();
        sc_hi = '0; sc_lo = '0; oc_lo = '0;
        settle();
        drive_edge();
        cmd_hi_n = 3'b101;
        settle();
        chk("R10 next pulse", gate_hi, 3'b010);
        chk("R10 flags after", {flt_n, cl_n}, 2'b11);
        idle();
    endtask

    initial begin
        t_reset();
        t_pass();
        t_interlock();
        t_short();
        t_warn();
        t_ignore();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule